// File: doc/BRIEF.md
# Guarded Sequential Instruction Prefetcher

This block sits beside a primary instruction cache and runs ahead of the fetch stream one cache line at a time. A demand-fetch miss starts a run at the line after the missed one. Each line request goes out on a valid/ready port. The cache then probes the line, taking it from the next level when the probe misses, and returns one response for it. That response says whether the line holds a compiler-placed end-of-run mark. With no mark the engine moves on to the next line. With a mark it stops and waits. While it waits, it watches the fetch addresses. A fetch that falls outside the span it last covered shows that the program has left that span without missing, and it starts a new run from there.

A translation-supplied per-page bit switches the marked behaviour on. When the bit is clear, a configuration input selects either a single plain next-line request or no prefetching at all. A software prefetch command starts a run at its own target line. A new miss or redirect always replaces the run in progress. If a line request is already in flight at that moment, its late response is dropped, and the new run's first request waits for it, so at most one request is ever outstanding. A build parameter removes the span check, and then every fetch seen while waiting restarts the engine.

Top module: `gseq_prefetch`

## Requirements
- R1: After reset the engine waits with no request valid and with both span bounds at address 0, so a fetch inside line 0 does not start a run when the span check is built in.
- R2: A fetch miss (fetch_valid and fetch_miss high) makes the engine present, in the next cycle, a request for the line after the missed one. Lines are LINE_BYTES = 32 bytes, and request addresses have their low 5 bits zero.
- R3: A response with pf_rsp_guard low makes the engine request the following line (address + 32) in the next cycle. A response with pf_rsp_guard high ends the run, and no further request is made.
- R4: Only one request is outstanding: after a request is accepted, no request is valid until its response has returned.
- R5: A request that is not accepted (pf_req_ready low) stays valid with the same address in the next cycle unless a new miss or redirect arrives.
- R6: A fetch miss during a run restarts the run from the line after the new miss. A response still owed to the old run is discarded when it arrives and does not advance the new run. The new run's first request waits until that response has come back.
- R7: While waiting and with the span check built in, a fetch whose line lies inside [first line of the last run, last line requested] starts nothing. A fetch outside that span starts a run at its line + 32.
- R8: With RANGE_CHECK = 0, every fetch seen while waiting starts a run at its line + 32, including fetches inside the last span.
- R9: With page_guard_en low at the trigger, fallback_nextline high gives exactly one request for the next line and the run then ends whatever pf_rsp_guard says. fallback_nextline low gives no request and abandons any run in progress.
- R10: A software prefetch (swpf_valid) starts a run at the line that holds swpf_addr itself, in either state. It takes priority over a fetch miss in the same cycle.
- R11: A miss that arrives in the same cycle as a response wins. The run restarts at the miss, and the new request is valid in the next cycle because that response has been consumed.
- R12: A fetch that hits during a run has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A demand fetch is issued this cycle |
| fetch_miss | input | 1 | That fetch missed the primary cache |
| fetch_addr | input | ADDR_W | Byte address of the demand fetch |
| page_guard_en | input | 1 | Per-page bit from translation: end-of-run marks are honoured |
| fallback_nextline | input | 1 | When the page bit is clear: 1 plain next-line, 0 no prefetch |
| swpf_valid | input | 1 | Software prefetch command |
| swpf_addr | input | ADDR_W | Target byte address of the software prefetch |
| pf_req_valid | output | 1 | Line request valid |
| pf_req_ready | input | 1 | Cache accepts the line request |
| pf_req_addr | output | ADDR_W | Line-aligned address of the request |
| pf_rsp_valid | input | 1 | The requested line is now present |
| pf_rsp_guard | input | 1 | That line holds at least one end-of-run mark |

## Verification
The case that matters is a restart arriving together with the end of a line transfer. A fetch miss can land in the very cycle a response is presented. It can also land while a request is accepted but not yet answered. The bench provokes the first case by waiting until its cache model drives the response and then raising the miss in that same cycle. It provokes the second by raising the miss while the model still owes a response. A behavioural per-cycle model predicts both outcomes: an immediate new request in the first case, and a held request followed by a discarded late response in the second. Every cycle of both instances, one with the span check and one without, is compared against it.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_PREF = 1'b1
   } gsp_state_e;

   typedef enum logic [1:0] {
      RUN_NONE    = 2'd0,
      RUN_SINGLE  = 2'd1,
      RUN_GUARDED = 2'd2
   } gsp_mode_e;
endpackage

// File: rtl/gsp_trigger.sv
module gsp_trigger
   import gsp_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32
) (
   input  logic              fetch_valid,
   input  logic              fetch_miss,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              page_guard_en,
   input  logic              fallback_nextline,
   input  logic              swpf_valid,
   input  logic [ADDR_W-1:0] swpf_addr,
   input  logic              idle,
   input  logic              in_range,
   output logic              trig,
   output logic [ADDR_W-1:0] tgt,
   output gsp_mode_e         mode
);
   localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'(LINE_BYTES - 1);
   localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(LINE_BYTES);

   logic [ADDR_W-1:0] fetch_line, swpf_line;
   logic              miss_ev, roam_ev;

   assign fetch_line = fetch_addr & ~OFS_MASK;
   assign swpf_line  = swpf_addr & ~OFS_MASK;
   assign miss_ev    = fetch_valid && fetch_miss;
   assign roam_ev    = fetch_valid && idle && !in_range;

   // software command first, then a miss, then an out-of-span idle fetch
   always_comb begin
      trig = 1'b1;
      tgt  = fetch_line + LINE_STEP;
      if (swpf_valid) begin
         tgt = swpf_line;
      end else if (!miss_ev && !roam_ev) begin
         trig = 1'b0;
      end
   end

   always_comb begin
      if (page_guard_en)          mode = RUN_GUARDED;
      else if (fallback_nextline) mode = RUN_SINGLE;
      else                        mode = RUN_NONE;
   end
endmodule

// File: rtl/gsp_ptrs.sv
module gsp_ptrs #(
   parameter int ADDR_W      = 32,
   parameter int LINE_BYTES  = 32,
   parameter bit RANGE_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] tgt,
   input  logic              adv,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic [ADDR_W-1:0] cur,
   output logic              in_range
);
   localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'(LINE_BYTES - 1);
   localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(LINE_BYTES);

   logic [ADDR_W-1:0] cur_q, lo, probe_line;

   always_ff @(posedge clk) begin
      if (!rst_n)    cur_q <= '0;
      else if (load) cur_q <= tgt;
      else if (adv)  cur_q <= cur_q + LINE_STEP;
   end

   generate
      if (RANGE_CHECK) begin : g_span
         logic [ADDR_W-1:0] start_q;
         always_ff @(posedge clk) begin
            if (!rst_n)    start_q <= '0;
            else if (load) start_q <= tgt;
         end
         assign lo = start_q;
      end else begin : g_nospan
         assign lo = cur_q;
      end
   endgenerate

   assign cur        = cur_q;
   assign probe_line = probe_addr & ~OFS_MASK;
   assign in_range   = RANGE_CHECK && (probe_line >= lo) && (probe_line <= cur_q);

   AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      adv && !load |=> cur_q == $past(cur_q) + LINE_STEP); // R3
   AST_LOAD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cur_q == $past(tgt)); // R2
endmodule

// File: rtl/gsp_fsm.sv
module gsp_fsm
   import gsp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      trig,
   input  gsp_mode_e mode,
   input  logic      req_ready,
   input  logic      rsp_valid,
   input  logic      rsp_guard,
   output logic      idle,
   output logic      load,
   output logic      adv,
   output logic      req_valid
);
   gsp_state_e st_q;
   logic       pend_q, busy_q, stale_q, single_q;
   logic       acc, busy_d, fresh_rsp;

   assign req_valid = (st_q == ST_PREF) && pend_q && !stale_q;
   assign acc       = req_valid && req_ready;
   assign busy_d    = (busy_q && !rsp_valid) || acc;
   assign fresh_rsp = rsp_valid && !stale_q && (st_q == ST_PREF);
   assign load      = trig && (mode != RUN_NONE);
   assign adv       = !trig && fresh_rsp && !rsp_guard && !single_q;
   assign idle      = (st_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         pend_q   <= 1'b0;
         busy_q   <= 1'b0;
         stale_q  <= 1'b0;
         single_q <= 1'b0;
      end else begin
         busy_q <= busy_d;
         if (trig) begin
            // whatever is still in flight now belongs to the abandoned run
            stale_q <= busy_d;
            if (load) begin
               st_q     <= ST_PREF;
               pend_q   <= 1'b1;
               single_q <= (mode == RUN_SINGLE);
            end else begin
               st_q   <= ST_IDLE;
               pend_q <= 1'b0;
            end
         end else begin
            if (rsp_valid) stale_q <= 1'b0;
            if (adv)       pend_q  <= 1'b1;
            else if (acc)  pend_q  <= 1'b0;
            if (fresh_rsp && (rsp_guard || single_q)) st_q <= ST_IDLE;
         end
      end
   end

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !busy_q); // R4
   AST_GUARD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      !trig && fresh_rsp && rsp_guard |=> idle && !req_valid); // R3
   AST_STALE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !trig && rsp_valid && stale_q |=> $stable(st_q) && !busy_q); // R6
endmodule

// File: rtl/gseq_prefetch.sv
module gseq_prefetch
   import gsp_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int LINE_BYTES  = 32,
   parameter bit RANGE_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   input  logic              fetch_miss,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              page_guard_en,
   input  logic              fallback_nextline,
   input  logic              swpf_valid,
   input  logic [ADDR_W-1:0] swpf_addr,
   output logic              pf_req_valid,
   input  logic              pf_req_ready,
   output logic [ADDR_W-1:0] pf_req_addr,
   input  logic              pf_rsp_valid,
   input  logic              pf_rsp_guard
);
   localparam int OFS_W = $clog2(LINE_BYTES);

   generate
      if (LINE_BYTES < 4 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("LINE_BYTES must be a power of two of at least 4");
      end
      if (ADDR_W <= OFS_W + 1) begin : g_bad_addr
         $error("ADDR_W too small for the line size");
      end
   endgenerate

   logic              trig, idle, in_range, load, adv;
   logic [ADDR_W-1:0] tgt;
   gsp_mode_e         mode;

   gsp_trigger #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_trig (
      .fetch_valid      (fetch_valid),
      .fetch_miss       (fetch_miss),
      .fetch_addr       (fetch_addr),
      .page_guard_en    (page_guard_en),
      .fallback_nextline(fallback_nextline),
      .swpf_valid       (swpf_valid),
      .swpf_addr        (swpf_addr),
      .idle             (idle),
      .in_range         (in_range),
      .trig             (trig),
      .tgt              (tgt),
      .mode             (mode)
   );

   gsp_ptrs #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .RANGE_CHECK(RANGE_CHECK)) u_ptrs (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .tgt       (tgt),
      .adv       (adv),
      .probe_addr(fetch_addr),
      .cur       (pf_req_addr),
      .in_range  (in_range)
   );

   gsp_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig     (trig),
      .mode     (mode),
      .req_ready(pf_req_ready),
      .rsp_valid(pf_rsp_valid),
      .rsp_guard(pf_rsp_guard),
      .idle     (idle),
      .load     (load),
      .adv      (adv),
      .req_valid(pf_req_valid)
   );

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pf_req_valid && !pf_req_ready && !trig |=> pf_req_valid && $stable(pf_req_addr)); // R5
   AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      pf_req_valid |-> (pf_req_addr & ADDR_W'(LINE_BYTES - 1)) == '0); // R2
endmodule

// File: tb/sim_gseq_prefetch.sv
`timescale 1ns/1ps
module sim_gseq_prefetch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fv = 1'b0, fm = 1'b0, pg = 1'b1, fb = 1'b1, swv = 1'b0;
   logic [31:0] fa = '0, swa = '0;
   logic        rv [2];
   logic [31:0] ra [2];
   logic        rdy [2];
   logic        rsp_v [2];
   logic        rsp_g [2];

   int nchk = 0, nerr = 0, ncyc = 0, lat = 2;
   bit rdy_slow = 1'b0;
   string phase = "R1";

   // behavioural reference state, one entry per instance
   bit          m_st [2], m_pend [2], m_busy [2], m_stale [2], m_single [2];
   logic [31:0] m_start [2], m_cur [2];
   int          rcnt [2], acc_cnt [2];
   logic [31:0] raddr [2];

   always #4 clk = ~clk;

   gseq_prefetch #(.RANGE_CHECK(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .fetch_valid(fv), .fetch_miss(fm), .fetch_addr(fa),
      .page_guard_en(pg), .fallback_nextline(fb), .swpf_valid(swv), .swpf_addr(swa),
      .pf_req_valid(rv[0]), .pf_req_ready(rdy[0]), .pf_req_addr(ra[0]),
      .pf_rsp_valid(rsp_v[0]), .pf_rsp_guard(rsp_g[0]));

   gseq_prefetch #(.RANGE_CHECK(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .fetch_valid(fv), .fetch_miss(fm), .fetch_addr(fa),
      .page_guard_en(pg), .fallback_nextline(fb), .swpf_valid(swv), .swpf_addr(swa),
      .pf_req_valid(rv[1]), .pf_req_ready(rdy[1]), .pf_req_addr(ra[1]),
      .pf_rsp_valid(rsp_v[1]), .pf_rsp_guard(rsp_g[1]));

   function automatic bit guard_of(logic [31:0] a);
      return a[9:5] == 5'd3;
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   task automatic model_step(int k);
      bit          acc, rsp, trig, span, stale_old, rc;
      logic [31:0] tgt, lfa, old_cur;
      int          mode;
      bit          nb;
      rc      = (k == 0);
      acc     = m_st[k] && m_pend[k] && !m_stale[k] && rdy[k];
      rsp     = rsp_v[k];
      old_cur = m_cur[k];
      lfa     = {fa[31:5], 5'b0};
      trig    = 1'b0;
      tgt     = lfa + 32'd32;
      span    = rc && lfa >= m_start[k] && lfa <= m_cur[k];
      if (swv) begin
         trig = 1'b1;
         tgt  = {swa[31:5], 5'b0};
      end else if (fv && fm) trig = 1'b1;
      else if (fv && !m_st[k] && !span) trig = 1'b1;
      mode = pg ? 2 : (fb ? 1 : 0);
      nb   = (m_busy[k] && !rsp) || acc;
      if (trig) begin
         m_stale[k] = nb;
         if (mode != 0) begin
            m_start[k] = tgt; m_cur[k] = tgt; m_st[k] = 1'b1; m_pend[k] = 1'b1;
            m_single[k] = (mode == 1);
         end else begin
            m_st[k] = 1'b0; m_pend[k] = 1'b0;
         end
      end else begin
         stale_old = m_stale[k];
         if (rsp) m_stale[k] = 1'b0;
         if (acc) m_pend[k] = 1'b0;
         if (rsp && !stale_old && m_st[k]) begin
            if (rsp_g[k] || m_single[k]) m_st[k] = 1'b0;
            else begin
               m_cur[k] = m_cur[k] + 32'd32;
               m_pend[k] = 1'b1;
            end
         end
      end
      m_busy[k] = nb;
      if (acc) begin
         rcnt[k]  = lat;
         raddr[k] = old_cur;
         acc_cnt[k]++;
      end
   endtask

   task automatic tick();
      @(posedge clk);
      if (rst_n) for (int k = 0; k < 2; k++) model_step(k);
      @(negedge clk);
      ncyc++;
      for (int k = 0; k < 2; k++) begin
         bit ev;
         ev = m_st[k] && m_pend[k] && !m_stale[k];
         chk(rv[k] == ev, $sformatf("%s u%0d req_valid", phase, k), 32'(rv[k]), 32'(ev));
         if (ev) chk(ra[k] == m_cur[k], $sformatf("%s u%0d req_addr", phase, k), ra[k], m_cur[k]);
         rsp_v[k] = 1'b0;
         rsp_g[k] = 1'b0;
         if (rcnt[k] > 0) begin
            rcnt[k]--;
            if (rcnt[k] == 0) begin
               rsp_v[k] = 1'b1;
               rsp_g[k] = guard_of(raddr[k]);
            end
         end
         rdy[k] = rdy_slow ? (ncyc % 3 == 0) : 1'b1;
      end
   endtask

   task automatic fetch(logic [31:0] a, bit miss);
      fv = 1'b1; fm = miss; fa = a;
      tick();
      fv = 1'b0; fm = 1'b0;
   endtask

   task automatic drain();
      repeat (30) tick();
   endtask

   task automatic clr_cnt();
      acc_cnt[0] = 0; acc_cnt[1] = 0;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=done", ncyc);
      summary();
   end

   initial begin
      for (int k = 0; k < 2; k++) begin
         m_st[k] = 0; m_pend[k] = 0; m_busy[k] = 0; m_stale[k] = 0; m_single[k] = 0;
         m_start[k] = '0; m_cur[k] = '0; rcnt[k] = 0; acc_cnt[k] = 0; raddr[k] = '0;
         rdy[k] = 1'b1; rsp_v[k] = 1'b0; rsp_g[k] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      chk(rv[0] == 1'b0 && rv[1] == 1'b0, "R1 idle after reset", 32'(rv[0]), 32'd0);

      // R1 / R8: fetch inside line 0 right after reset
      fetch(32'h0000_0010, 1'b0);
      chk(rv[0] == 1'b0, "R1 line 0 inside reset span", 32'(rv[0]), 32'd0);
      chk(rv[1] && ra[1] == 32'h20, "R8 no span check restarts", ra[1], 32'h20);
      drain();

      // R2 / R3: miss starts a marked run that stops at the marked line
      phase = "R3"; clr_cnt();
      fetch(32'h0000_1004, 1'b1);
      chk(rv[0] && ra[0] == 32'h1020, "R2 line after miss", ra[0], 32'h1020);
      drain();
      chk(acc_cnt[0] == 3, "R3 run length to mark", 32'(acc_cnt[0]), 32'd3);
      chk(rv[0] == 1'b0, "R3 stopped after mark", 32'(rv[0]), 32'd0);

      // R7: span boundaries while waiting
      phase = "R7";
      fetch(32'h0000_107c, 1'b0);
      chk(rv[0] == 1'b0, "R7 last line in span", 32'(rv[0]), 32'd0);
      chk(rv[1] && ra[1] == 32'h1080, "R8 in-span fetch restarts", ra[1], 32'h1080);
      drain();
      fetch(32'h0000_101c, 1'b0);
      chk(rv[0] && ra[0] == 32'h1020, "R7 below span restarts", ra[0], 32'h1020);
      drain();
      fetch(32'h0000_2000, 1'b0);
      chk(rv[0] && ra[0] == 32'h2020, "R7 far fetch restarts", ra[0], 32'h2020);
      drain();

      // R5: slow acceptance
      phase = "R5"; rdy_slow = 1'b1; clr_cnt();
      fetch(32'h0000_5000, 1'b1);
      repeat (40) tick();
      chk(acc_cnt[0] == 3, "R5 all lines accepted", 32'(acc_cnt[0]), 32'd3);
      rdy_slow = 1'b0;
      drain();

      // R6: restart while a request is in flight
      phase = "R6"; clr_cnt();
      fetch(32'h0000_6000, 1'b1);
      while (!(m_busy[0] && !rsp_v[0])) tick();
      fetch(32'h0000_7000, 1'b1);
      chk(rv[0] == 1'b0, "R6 new request held for stale reply", 32'(rv[0]), 32'd0);
      drain();
      chk(acc_cnt[0] == 4, "R6 stale reply did not advance", 32'(acc_cnt[0]), 32'd4);

      // R12: fetch hit during a run
      phase = "R12";
      fetch(32'h0000_8000, 1'b1);
      clr_cnt();
      fetch(32'h0000_9000, 1'b0);
      drain();
      chk(acc_cnt[0] == 3, "R12 hit left run intact", 32'(acc_cnt[0]), 32'd3);

      // R11: miss in the same cycle as a response
      phase = "R11";
      fetch(32'h0000_a000, 1'b1);
      while (!rsp_v[0]) tick();
      fetch(32'h0000_b000, 1'b1);
      chk(rv[0] && ra[0] == 32'h0000_b020, "R11 miss wins over reply", ra[0], 32'h0000_b020);
      drain();

      // R9: page bit clear
      phase = "R9"; pg = 1'b0; fb = 1'b1; clr_cnt();
      fetch(32'h0000_c000, 1'b1);
      chk(rv[0] && ra[0] == 32'h0000_c020, "R9 single next line", ra[0], 32'h0000_c020);
      drain();
      chk(acc_cnt[0] == 1, "R9 single line only", 32'(acc_cnt[0]), 32'd1);
      fb = 1'b0; clr_cnt();
      fetch(32'h0000_d000, 1'b1);
      chk(rv[0] == 1'b0, "R9 no prefetch mode", 32'(rv[0]), 32'd0);
      drain();
      chk(acc_cnt[0] == 0, "R9 nothing requested", 32'(acc_cnt[0]), 32'd0);
      pg = 1'b1;
      fetch(32'h0000_e000, 1'b1);
      tick();
      pg = 1'b0; clr_cnt();
      fetch(32'h0000_f000, 1'b1);
      pg = 1'b1;
      drain();
      chk(acc_cnt[0] <= 1, "R9 run abandoned", 32'(acc_cnt[0]), 32'd1);

      // R10: software prefetch
      phase = "R10";
      swv = 1'b1; swa = 32'h0000_4010;
      tick();
      swv = 1'b0;
      chk(rv[0] && ra[0] == 32'h0000_4000, "R10 starts at target line", ra[0], 32'h0000_4000);
      drain();
      swv = 1'b1; swa = 32'h0000_4410;
      fetch(32'h0000_9000, 1'b1);
      swv = 1'b0;
      chk(rv[0] && ra[0] == 32'h0000_4400, "R10 beats miss", ra[0], 32'h0000_4400);
      drain();

      summary();
   end
endmodule